// File: doc/BRIEF.md
# Dual-Mode Branch Metric Unit

This block sits at the front of a maximum-selecting Viterbi decoder for a rate-1/2 convolutional code. Each time a new pair of received symbols is presented with a strobe, it produces one branch metric for every possible two-bit code word. The add-compare-select stage then looks up the metric it needs for each trellis branch. Which code word belongs to which branch is decided in that later stage, not here.

Two metric styles are selectable per received pair. In soft mode, each symbol is a 3-bit offset-binary sample that stands for an odd level between -7 and +7. The metric is a correlation built only from sign flips: a lane's value is added when the code bit is 1 and subtracted when it is 0. The received-energy and code-energy terms are dropped, since every branch shares them equally. In hard mode, only the top bit of each sample is used as the received bit, and the metric counts the lanes where that bit matches the code bit. Under both conventions a larger metric means a more likely branch.

The metrics are registered. They appear one clock after the input strobe, together with an output strobe, and stay unchanged until the next strobe.

Top module: `bmu_top`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise.
- R2: Lane i of `sym_i` is bits [3i+2:3i]. In soft mode a code q (0..7) stands for the signed level 2q-7.
- R3: In soft mode the metric for code word c (0..3) is the sum over lanes i of +level when bit i of c is 1, and -level when it is 0.
- R4: Metric c is placed at `metric_o[5c+4:5c]` in 5-bit two's complement. The soft extremes +14 and -14 are represented exactly, with no wrap.
- R5: In hard mode the received bit of lane i is bit 3i+2 of `sym_i`. Metric c is the number of lanes whose received bit equals bit i of c, giving 0, 1 or 2.
- R6: `hard_mode` is sampled in the same cycle as `in_valid`, so consecutive strobes may alternate modes.
- R7: While `in_valid` is low, `metric_o` keeps its last value whatever `sym_i` and `hard_mode` do.
- R8: During and right after reset, `out_valid` is 0 and every metric is 0.
- R9: Metrics of complementary code words c and 3-c sum to 0 in soft mode and to 2 in hard mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A new received pair is present on `sym_i` |
| hard_mode | input | 1 | 1 selects Hamming agreement, 0 selects soft correlation |
| sym_i | input | 6 | Two 3-bit received samples, lane 0 in the low bits |
| out_valid | output | 1 | `metric_o` holds a fresh set of metrics |
| metric_o | output | 20 | Four signed 5-bit metrics, code word 0 in the low bits |

## Verification
Two things can happen in the same cycle: the result of one strobe is loaded into the output register, and the mode for the next strobe changes. The bench provokes this by issuing strobes back to back while toggling `hard_mode` between soft and hard on every strobe. It checks that each output set matches the mode that was present with its own strobe, and not the mode of the strobe that follows. Idle cycles with random samples and a random mode are placed between strobes; after each one the metrics must still equal the last expected set.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int LANES_DEF  = 2;
  localparam int QBITS_DEF  = 3;
  localparam int MBITS_DEF  = 5;
endpackage

// File: rtl/bmu_symbol_map.sv
module bmu_symbol_map #(
  parameter int LANES = bmu_pkg::LANES_DEF,
  parameter int QBITS = bmu_pkg::QBITS_DEF,
  parameter int MBITS = bmu_pkg::MBITS_DEF
) (
  input  logic [LANES*QBITS-1:0] sym_i,
  output logic [LANES*MBITS-1:0] level_o,
  output logic [LANES-1:0]       hbit_o
);
  localparam logic [MBITS-1:0] MID = MBITS'(1 << QBITS);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [QBITS-1:0] code;
    logic [MBITS-1:0] odd;
    assign code = sym_i[i*QBITS +: QBITS];
    // level = 2q + 1 - 2^QBITS, an odd value symmetric about zero
    assign odd  = MBITS'({code, 1'b1});
    assign level_o[i*MBITS +: MBITS] = odd - MID;
    assign hbit_o[i] = code[QBITS-1];
  end
endmodule

// File: rtl/bmu_metric_sum.sv
module bmu_metric_sum #(
  parameter int LANES = bmu_pkg::LANES_DEF,
  parameter int MBITS = bmu_pkg::MBITS_DEF,
  localparam int NCW  = 1 << LANES
) (
  input  logic [LANES*MBITS-1:0] level_i,
  input  logic [LANES-1:0]       hbit_i,
  input  logic                   hard_i,
  output logic [NCW*MBITS-1:0]   metric_o
);
  for (genvar c = 0; c < NCW; c++) begin : g_cw
    localparam logic [LANES-1:0] CW = LANES'(c);
    logic signed [MBITS-1:0] acc;
    always_comb begin
      acc = '0;
      for (int i = 0; i < LANES; i++) begin
        if (hard_i) begin
          if (hbit_i[i] == CW[i]) acc = acc + MBITS'(1);
        end else if (CW[i]) begin
          acc = acc + $signed(level_i[i*MBITS +: MBITS]);
        end else begin
          acc = acc - $signed(level_i[i*MBITS +: MBITS]);
        end
      end
    end
    assign metric_o[c*MBITS +: MBITS] = acc;
  end

  for (genvar c = 0; c < NCW/2; c++) begin : g_pair
    logic signed [MBITS:0] pair;
    assign pair = MBITS'(0) + $signed(g_cw[c].acc) + $signed(g_cw[NCW-1-c].acc);
    always_comb begin
      // R9
      complement_pair_chk: assert (pair == (hard_i ? (MBITS+1)'(LANES) : '0))
        else $error("complement pair %0d sums to %0d", c, pair);
    end
  end
endmodule

// File: rtl/bmu_top.sv
module bmu_top #(
  parameter int LANES = bmu_pkg::LANES_DEF,
  parameter int QBITS = bmu_pkg::QBITS_DEF,
  parameter int MBITS = bmu_pkg::MBITS_DEF,
  localparam int NCW  = 1 << LANES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   hard_mode,
  input  logic [LANES*QBITS-1:0] sym_i,
  output logic                   out_valid,
  output logic [NCW*MBITS-1:0]   metric_o
);
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  logic [LANES*MBITS-1:0] level;
  logic [LANES-1:0]       hbit;
  logic [NCW*MBITS-1:0]   metric_c;

  bmu_symbol_map #(.LANES(LANES), .QBITS(QBITS), .MBITS(MBITS)) u_map (
    .sym_i(sym_i), .level_o(level), .hbit_o(hbit)
  );

  bmu_metric_sum #(.LANES(LANES), .MBITS(MBITS)) u_sum (
    .level_i(level), .hbit_i(hbit), .hard_i(hard_mode), .metric_o(metric_c)
  );

  logic                 vld_d, vld_q;
  logic [NCW*MBITS-1:0] met_d, met_q;

  always_comb begin
    vld_d = in_valid;
    met_d = in_valid ? metric_c : met_q;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      vld_q <= 1'b0;
      met_q <= '0;
    end else begin
      vld_q <= vld_d;
      met_q <= met_d;
    end
  end

  assign out_valid = vld_q;
  assign metric_o  = met_q;

  // R1
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_valid);
  // R1
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> !out_valid);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> $stable(metric_o));
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rst_ok |-> (!out_valid && metric_o == '0));
endmodule

// File: tb/sim_bmu_top.sv
`timescale 1ns/1ps
module sim_bmu_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        hard_mode;
  logic [5:0]  sym_i;
  logic        out_valid;
  logic [19:0] metric_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [19:0] last_exp;

  always #2.5 clk = ~clk;

  bmu_top u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hard_mode(hard_mode),
              .sym_i(sym_i), .out_valid(out_valid), .metric_o(metric_o));

  function automatic logic [4:0] exp_one(input logic hm, input logic [5:0] s, input int c);
    int acc = 0;
    for (int i = 0; i < 2; i++) begin
      logic [2:0] q;
      int lv;
      q = s[i*3 +: 3];
      lv = 2 * int'(q) - 7;
      if (hm) acc += (q[2] == c[i]) ? 1 : 0;
      else    acc += c[i] ? lv : -lv;
    end
    return acc[4:0];
  endfunction

  function automatic logic [19:0] exp_all(input logic hm, input logic [5:0] s);
    logic [19:0] r;
    for (int c = 0; c < 4; c++) r[c*5 +: 5] = exp_one(hm, s, c);
    return r;
  endfunction

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] ex);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, ex);
    end
  endtask

  task automatic strobe(input string req, input logic hm, input logic [5:0] s);
    in_valid = 1'b1; hard_mode = hm; sym_i = s;
    @(negedge clk);
    last_exp = exp_all(hm, s);
    check("R1", {19'b0, out_valid}, 20'd1);
    check(req, metric_o, last_exp);
  endtask

  task automatic idle();
    in_valid = 1'b0; hard_mode = 1'($urandom); sym_i = 6'($urandom);
    @(negedge clk);
    check("R1", {19'b0, out_valid}, 20'd0);
    check("R7", metric_o, last_exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0b17));
    rst_n = 1'b0; in_valid = 1'b0; hard_mode = 1'b0; sym_i = '0;
    repeat (4) @(negedge clk);
    check("R8", {out_valid, 19'b0}, 20'd0);
    check("R8", metric_o, 20'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", {out_valid, 19'b0}, 20'd0);
    check("R8", metric_o, 20'd0);
    last_exp = '0;

    // R4 soft extremes: both lanes at +7 and at -7
    strobe("R4", 1'b0, 6'b111_111);
    check("R4", {15'b0, metric_o[19:15]}, {15'b0, 5'd14});
    strobe("R4", 1'b0, 6'b000_000);
    check("R4", {15'b0, metric_o[4:0]}, {15'b0, 5'd14});
    // R2 level mapping: lane0 code 4 (+1), lane1 code 3 (-1)
    strobe("R2", 1'b0, 6'b011_100);
    strobe("R3", 1'b0, 6'b001_110);
    idle();
    // R5 hard mode: lane0 top bit 1, lane1 top bit 0 -> only code word 1 gets 2
    strobe("R5", 1'b1, 6'b011_100);
    check("R5", {15'b0, metric_o[9:5]}, {15'b0, 5'd2});
    strobe("R5", 1'b1, 6'b111_111);
    // R6 alternating modes back to back
    for (int k = 0; k < 40; k++) strobe("R6", k[0], 6'($urandom));
    idle();

    for (int k = 0; k < 600; k++) begin
      if ($urandom_range(0, 3) != 0) strobe("R3", 1'($urandom), 6'($urandom));
      else idle();
    end

    // R8 reset in the middle of traffic
    strobe("R3", 1'b0, 6'b101_010);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8", {out_valid, 19'b0}, 20'd0);
    check("R8", metric_o, 20'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule